// File: doc/BRIEF.md
# Byte-Wide SPI Master/Slave Controller

This block is an 8-bit serial engine that takes either end of an SPI link. A processor drives it through three byte-wide registers on a simple select/read/write bus: a control register, a status register and a data register. As master it makes SCLK from the system clock, shifts a byte out on MOSI and takes one in on MISO. As slave it follows an external SCLK, resynchronised into the system clock, while its active-low select input is low.

The core is a four-state machine. ST_IDLE waits. In master role a data-register write moves it to ST_LEAD. In slave role a leading SCLK edge moves it to ST_TRAIL. ST_LEAD waits for the leading clock edge and then goes to ST_TRAIL. ST_TRAIL waits for the trailing edge, then returns to ST_LEAD, or goes to ST_FINISH after the eighth bit. ST_FINISH copies the received byte into the readable data register, raises the done flag and goes back to ST_IDLE. Clearing the enable bit returns ST_LEAD or ST_TRAIL to ST_IDLE. So does a slave select that goes high during a slave transfer.

Top module: `spi_port`

## Requirements
- R1: Control bit 6 enables the controller. While it is 0, the state machine stays idle, SCLK holds its idle level, no transfer starts and `miso_oe` stays 0.
- R2: Control bit 7 chooses how the role is set. When it is 1, control bit 4 picks the role (1 = master). When it is 0, `ss_n_i` high gives master and `ss_n_i` low gives slave.
- R3: Control bit 5 set sends and receives the least significant bit first. When it is clear, the most significant bit goes first.
- R4: Control bit 3 is the SCLK idle level. When it is 1, SCLK rests high. When it is 0, SCLK rests low.
- R5: Control bit 2 set samples data on the trailing (second) SCLK edge of each bit and changes data on the leading edge. When it is clear, data is sampled on the leading edge and changes on the trailing edge.
- R6: In master role a data write starts a transfer. Control bits 1:0 set the SCLK period to 4, 16, 64 or 128 system clocks for codes 0 to 3.
- R7: Status bit 7 is set when a byte completes. It clears only when the data register is read after a status read that saw a flag set. A data read on its own leaves it set.
- R8: Writing the data register while a transfer is in progress sets status bit 6 and leaves the byte being shifted unchanged. The same status-then-data read sequence clears bit 6.
- R9: In slave role the byte is clocked by the external SCLK and completes after eight bits. `miso_oe` is 1 only while enabled as slave with `ss_n_i` low.
- R10: Address 0 reads back the control register. Address 1 reads status (bit 7 done, bit 6 collision, others 0). Address 2 reads the last received byte.
- R11: After reset, control and status read 0, SCLK is low and `miso_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (clear side effects) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| sclk_o | output | 1 | SCLK driven in master role |
| sclk_i | input | 1 | SCLK received in slave role |
| mosi_o | output | 1 | Serial data out in master role |
| mosi_i | input | 1 | Serial data in for slave role |
| miso_o | output | 1 | Serial data out for slave role |
| miso_i | input | 1 | Serial data in for master role |
| miso_oe | output | 1 | Output enable for `miso_o` |
| ss_n_i | input | 1 | Active-low slave select |

## Verification
The bench runs all four polarity/phase pairings in both bit orders against a model of the far end. A controller that samples on the wrong edge or shifts the wrong way would return a byte that is shifted or bit-reversed. It measures the SCLK period for several rate codes, which catches a divider that is off by a factor of two. It reads the data register without a status read first, and a flag that cleared on that read alone would be caught. It also writes during a transfer, because a controller that reloaded its shifter would put a corrupted byte on the wire. Finally it runs slave transfers under both role-selection rules, and checks that the data output is released when the select pin goes high.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTL  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd2;

    localparam int CTL_IGN  = 7;
    localparam int CTL_EN   = 6;
    localparam int CTL_LSB  = 5;
    localparam int CTL_MST  = 4;
    localparam int CTL_CPOL = 3;
    localparam int CTL_CPHA = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_TRAIL,
        ST_FINISH
    } spi_state_e;
endpackage

// File: rtl/spi_port_sync.sv
module spi_port_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d};
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/spi_port_clkdiv.sv
module spi_port_clkdiv #(
    parameter int CNT_W = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] rate,
    output logic       tick
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] half_m1;

    // half period minus one, in system clocks, for divisors 4/16/64/128
    always_comb begin
        unique case (rate)
            2'd0: half_m1 = CNT_W'(1);
            2'd1: half_m1 = CNT_W'(7);
            2'd2: half_m1 = CNT_W'(31);
            2'd3: half_m1 = CNT_W'(63);
        endcase
    end

    assign tick = run && (cnt_q == half_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/spi_port_engine.sv
module spi_port_engine
    import spi_port_pkg::*;
#(
    parameter int BITS = 8,
    localparam int CW = $clog2(BITS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            master,
    input  logic            cpha,
    input  logic            lsb_first,
    input  logic            load,
    input  logic [BITS-1:0] load_byte,
    input  logic            start,
    input  logic            tick,
    input  logic            slv_lead,
    input  logic            slv_trail,
    input  logic            slv_abort,
    input  logic            ser_in,
    output logic            ser_out,
    output logic            sclk_active,
    output logic            busy,
    output logic            finish,
    output logic [BITS-1:0] rx_byte
);
    spi_state_e state_q, state_d;

    logic [BITS-1:0] sh_q;
    logic [CW-1:0]   cnt_q;
    logic            samp_q;
    logic            out_q;
    logic            lead_ev;
    logic            trail_ev;
    logic            abort;
    logic            last_bit;
    logic            head_bit;
    logic            shift_in;

    assign head_bit = lsb_first ? sh_q[0] : sh_q[BITS-1];
    assign last_bit = (cnt_q == CW'(BITS-1));
    assign abort    = !en || (!master && slv_abort);
    assign lead_ev  = master ? (state_q == ST_LEAD && tick)
                             : (slv_lead && (state_q == ST_IDLE || state_q == ST_LEAD));
    assign trail_ev = master ? (state_q == ST_TRAIL && tick)
                             : (slv_trail && state_q == ST_TRAIL);
    assign shift_in = cpha ? ser_in : samp_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (en && master && start) begin
                    state_d = ST_LEAD;
                end else if (en && !master && lead_ev) begin
                    state_d = ST_TRAIL;
                end
            end
            ST_LEAD: begin
                if (abort) begin
                    state_d = ST_IDLE;
                end else if (lead_ev) begin
                    state_d = ST_TRAIL;
                end
            end
            ST_TRAIL: begin
                if (abort) begin
                    state_d = ST_IDLE;
                end else if (trail_ev) begin
                    state_d = last_bit ? ST_FINISH : ST_LEAD;
                end
            end
            ST_FINISH: state_d = ST_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q    <= '0;
            cnt_q   <= '0;
            samp_q  <= 1'b0;
            out_q   <= 1'b0;
            rx_byte <= '0;
        end else begin
            if (state_q == ST_IDLE) begin
                cnt_q <= '0;
                if (load) begin
                    sh_q <= load_byte;
                end
            end
            if (en && lead_ev) begin
                if (cpha) begin
                    out_q <= head_bit;
                end else begin
                    samp_q <= ser_in;
                end
            end
            if (en && trail_ev) begin
                sh_q  <= lsb_first ? {shift_in, sh_q[BITS-1:1]}
                                   : {sh_q[BITS-2:0], shift_in};
                cnt_q <= cnt_q + CW'(1);
            end
            if (state_q == ST_FINISH) begin
                rx_byte <= sh_q;
            end
        end
    end

    // outputs
    always_comb begin
        ser_out     = cpha ? out_q : head_bit;
        sclk_active = master && (state_q == ST_TRAIL);
        busy        = (state_q != ST_IDLE);
        finish      = (state_q == ST_FINISH);
    end
endmodule

// File: rtl/spi_port.sv
module spi_port
    import spi_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sclk_o,
    input  logic              sclk_i,
    output logic              mosi_o,
    input  logic              mosi_i,
    output logic              miso_o,
    input  logic              miso_i,
    output logic              miso_oe,
    input  logic              ss_n_i
);
    logic [DATA_W-1:0] ctl_q;
    logic [DATA_W-1:0] rx_byte;
    logic              done_q;
    logic              wcol_q;
    logic              armed_q;

    logic ss_s, sclk_s, sclk_d;
    logic en, is_master, cpol;
    logic wr_ctl, wr_data, rd_stat, rd_data;
    logic eng_busy, eng_finish, eng_active, eng_out, tick;
    logic slv_lead, slv_trail, sclk_chg;

    spi_port_sync #(.STAGES(2), .RST_VAL(1'b1)) u_ss_sync (
        .clk(clk), .rst_n(rst_n), .d(ss_n_i), .q(ss_s)
    );
    spi_port_sync #(.STAGES(2), .RST_VAL(1'b0)) u_sclk_sync (
        .clk(clk), .rst_n(rst_n), .d(sclk_i), .q(sclk_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
        end
    end

    assign en        = ctl_q[CTL_EN];
    assign cpol      = ctl_q[CTL_CPOL];
    assign is_master = ctl_q[CTL_IGN] ? ctl_q[CTL_MST] : ss_s;
    assign sclk_chg  = (sclk_s != sclk_d);
    assign slv_lead  = !ss_s && sclk_chg && (sclk_s != cpol);
    assign slv_trail = !ss_s && sclk_chg && (sclk_s == cpol);

    assign wr_ctl  = bus_sel && bus_wr && (bus_addr == ADDR_CTL);
    assign wr_data = bus_sel && bus_wr && (bus_addr == ADDR_DATA);
    assign rd_stat = bus_sel && bus_rd && (bus_addr == ADDR_STAT);
    assign rd_data = bus_sel && bus_rd && (bus_addr == ADDR_DATA);

    spi_port_clkdiv #(.CNT_W(7)) u_div (
        .clk(clk), .rst_n(rst_n),
        .run(eng_busy && is_master),
        .rate(ctl_q[1:0]),
        .tick(tick)
    );

    spi_port_engine #(.BITS(DATA_W)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .en(en), .master(is_master),
        .cpha(ctl_q[CTL_CPHA]), .lsb_first(ctl_q[CTL_LSB]),
        .load(wr_data && !eng_busy), .load_byte(bus_wdata),
        .start(wr_data && !eng_busy),
        .tick(tick),
        .slv_lead(slv_lead), .slv_trail(slv_trail), .slv_abort(ss_s),
        .ser_in(is_master ? miso_i : mosi_i),
        .ser_out(eng_out), .sclk_active(eng_active),
        .busy(eng_busy), .finish(eng_finish),
        .rx_byte(rx_byte)
    );

    // register file and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q   <= '0;
            done_q  <= 1'b0;
            wcol_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            if (wr_ctl) begin
                ctl_q <= bus_wdata;
            end
            if (rd_stat && (done_q || wcol_q)) begin
                armed_q <= 1'b1;
            end
            if (rd_data && armed_q) begin
                done_q  <= 1'b0;
                wcol_q  <= 1'b0;
                armed_q <= 1'b0;
            end
            if (wr_data && eng_busy) begin
                wcol_q <= 1'b1;
            end
            if (eng_finish) begin
                done_q <= 1'b1;
            end
        end
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_CTL:  bus_rdata = ctl_q;
            ADDR_STAT: bus_rdata = {done_q, wcol_q, {(DATA_W-2){1'b0}}};
            ADDR_DATA: bus_rdata = rx_byte;
            default:   bus_rdata = '0;
        endcase
    end

    assign sclk_o  = cpol ^ eng_active;
    assign mosi_o  = en && is_master && eng_out;
    assign miso_o  = eng_out;
    assign miso_oe = en && !is_master && !ss_s;
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic       cpol,
    input logic       sclk_o,
    input logic       busy,
    input logic       done,
    input logic       wcol,
    input logic       miso_oe,
    input logic       bus_sel,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [1:0] bus_addr
);
    p_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !busy)
        else $error("R1: engine busy while disabled");

    p_off_oe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !miso_oe)
        else $error("R1: MISO driven while disabled");

    p_sclk_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk_o == cpol))
        else $error("R4: SCLK off its idle level while idle");

    p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !(bus_sel && bus_rd && bus_addr == 2'd2)) |=> done)
        else $error("R7: done flag dropped without a data read");

    p_wcol_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wcol) |-> $past(bus_sel && bus_wr && bus_addr == 2'd2 && busy))
        else $error("R8: collision flag without a write during transfer");
endmodule

bind spi_port spi_port_chk u_chk (
    .clk(clk), .rst_n(rst_n),
    .en(ctl_q[6]), .cpol(ctl_q[3]),
    .sclk_o(sclk_o), .busy(eng_busy),
    .done(done_q), .wcol(wcol_q), .miso_oe(miso_oe),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr)
);

// File: tb/spi_port_bench.sv
module spi_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       sclk_o, mosi_o, miso_o, miso_oe;
    logic       sclk_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0, ss_n_i = 1'b1;

    spi_port u_spi_port (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk_o(sclk_o), .sclk_i(sclk_i), .mosi_o(mosi_o), .mosi_i(mosi_i),
        .miso_o(miso_o), .miso_i(miso_i), .miso_oe(miso_oe), .ss_n_i(ss_n_i)
    );

    always #10 clk = ~clk;   // 50 MHz

    int checks = 0;
    int errs   = 0;
    int cyc    = 0;
    int edges  = 0;
    int rise_prev = 0, rise_last = 0;
    bit finished = 0;

    always @(posedge clk) cyc++;
    always @(sclk_o) edges++;
    always @(posedge sclk_o) begin
        rise_prev = rise_last;
        rise_last = cyc;
    end

    // scoreboard
    typedef struct { logic [7:0] val; string tag; } exp_t;
    exp_t exp_q[$];
    logic [7:0] obs_val;
    event obs_ev;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    always @(obs_ev) begin
        if (exp_q.size() == 0) begin
            check("scoreboard-empty", obs_val, 8'hxx);
        end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.tag, obs_val, e.val);
        end
    end

    function automatic logic bit_of(input logic [7:0] b, input int i, input logic lsb);
        return lsb ? b[i] : b[7-i];
    endfunction

    // far-end slave model for master-role transfers
    bit         mdl_on = 0;
    logic       mdl_cpol, mdl_cpha, mdl_lsb;
    logic [7:0] mdl_tx, cap;
    int         k;

    always @(sclk_o) begin
        if (mdl_on && k < 8) begin
            if (sclk_o != mdl_cpol) begin
                if (mdl_cpha) miso_i = bit_of(mdl_tx, k, mdl_lsb);
                else cap[mdl_lsb ? k : 7-k] = mosi_o;
            end else begin
                if (mdl_cpha) cap[mdl_lsb ? k : 7-k] = mosi_o;
                k++;
                if (!mdl_cpha && k < 8) miso_i = bit_of(mdl_tx, k, mdl_lsb);
            end
        end
    end

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_rd = 1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0; bus_rd = 0;
    endtask

    task automatic wait_done();
        logic [7:0] s;
        for (int i = 0; i < 3000; i++) begin
            bus_read(2'd1, s);
            if (s[7]) return;
        end
        check("wait_done-timeout", 8'h00, 8'h80);
    endtask

    task automatic collect(input string tag);
        logic [7:0] d;
        bus_read(2'd2, d);
        obs_val = d;
        -> obs_ev;
        #1;
    endtask

    task automatic run_master(input logic [7:0] ctl, input logic [7:0] tx,
                              input logic [7:0] sl, input string tag);
        bus_write(2'd0, ctl);
        mdl_cpol = ctl[3]; mdl_cpha = ctl[2]; mdl_lsb = ctl[5];
        mdl_tx = sl; cap = 8'h00; k = 0;
        miso_i = ctl[2] ? 1'b0 : bit_of(sl, 0, ctl[5]);
        mdl_on = 1;
        exp_q.push_back('{val: sl, tag: {tag, " rx"}});
        bus_write(2'd2, tx);
        wait_done();
        collect(tag);
        mdl_on = 0;
        check({tag, " tx on wire"}, cap, tx);
    endtask

    task automatic run_slave(input logic [7:0] ctl, input logic [7:0] mo,
                             input logic [7:0] sl, input string tag);
        logic [7:0] rcv;
        logic cpol, cpha, lsb;
        cpol = ctl[3]; cpha = ctl[2]; lsb = ctl[5];
        rcv = 8'h00;
        bus_write(2'd0, ctl);
        @(negedge clk); sclk_i = cpol; ss_n_i = 0;
        repeat (4) @(negedge clk);
        check({tag, " R9 oe while selected"}, {7'd0, miso_oe}, 8'h01);
        bus_write(2'd2, sl);
        repeat (6) @(negedge clk);
        if (!cpha) mosi_i = bit_of(mo, 0, lsb);
        for (int i = 0; i < 8; i++) begin
            if (cpha) mosi_i = bit_of(mo, i, lsb);
            sclk_i = ~cpol;
            if (!cpha) rcv[lsb ? i : 7-i] = miso_o;
            repeat (6) @(negedge clk);
            sclk_i = cpol;
            if (cpha) rcv[lsb ? i : 7-i] = miso_o;
            else if (i < 7) mosi_i = bit_of(mo, i+1, lsb);
            repeat (6) @(negedge clk);
        end
        ss_n_i = 1;
        repeat (4) @(negedge clk);
        check({tag, " R9 oe released"}, {7'd0, miso_oe}, 8'h00);
        exp_q.push_back('{val: mo, tag: {tag, " rx"}});
        wait_done();
        collect(tag);
        check({tag, " tx on wire"}, rcv, sl);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errs++;
        $display("FAIL watchdog: actual=hung expected=complete");
        finish_run();
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R11 reset state
        bus_read(2'd0, r); check("R11 control", r, 8'h00);
        bus_read(2'd1, r); check("R11 status", r, 8'h00);
        check("R11 sclk/oe", {6'd0, sclk_o, miso_oe}, 8'h00);

        // R10 control readback
        bus_write(2'd0, 8'h2B);
        bus_read(2'd0, r); check("R10 control readback", r, 8'h2B);
        bus_write(2'd0, 8'h00);

        // R3 R5 R6 master modes (R2: ignore bit set, master bit set)
        run_master(8'hD0, 8'hA7, 8'h5C, "R3 R5 msb cpha0");
        check("R6 period rate0", 8'(rise_last - rise_prev), 8'd4);
        run_master(8'hF5, 8'h1E, 8'hC3, "R3 R5 lsb cpha1");
        check("R6 period rate1", 8'(rise_last - rise_prev), 8'd16);
        bus_write(2'd0, 8'hF8);
        @(negedge clk);
        check("R4 idle high", {7'd0, sclk_o}, 8'h01);
        run_master(8'hF8, 8'h96, 8'h0F, "R4 cpol1 lsb cpha0");
        run_master(8'hDE, 8'h3D, 8'hE1, "R4 R5 cpol1 cpha1 msb");
        check("R6 period rate2", 8'(rise_last - rise_prev), 8'd64);
        run_master(8'hD3, 8'h81, 8'h7E, "R6 rate3");
        check("R6 period rate3", 8'(rise_last - rise_prev), 8'd128);

        // R2 role from the pin: high = master
        ss_n_i = 1;
        run_master(8'h40, 8'h44, 8'hB2, "R2 pin-high master");

        // R9 slave transfers under both role rules
        run_slave(8'h40, 8'h6A, 8'h95, "R9 R2 pin-low slave cpha0");
        run_slave(8'hE4, 8'hC8, 8'h27, "R9 R2 ignore slave cpha1 lsb");

        // R7 done flag clearing sequence
        bus_write(2'd0, 8'hD0);
        mdl_cpol = 0; mdl_cpha = 0; mdl_lsb = 0; mdl_tx = 8'h33; cap = 0; k = 0;
        miso_i = 1'b0; mdl_on = 1;
        bus_write(2'd2, 8'h55);
        repeat (200) @(negedge clk);
        mdl_on = 0;
        bus_read(2'd2, r); check("R7 data", r, 8'h33);
        bus_read(2'd1, r); check("R7 data-only read keeps done", r, 8'h80);
        bus_read(2'd2, r);
        bus_read(2'd1, r); check("R7 status-then-data clears", r, 8'h00);

        // R8 write collision
        bus_write(2'd0, 8'hD1);
        mdl_cpol = 0; mdl_cpha = 0; mdl_lsb = 0; mdl_tx = 8'h3C; cap = 0; k = 0;
        miso_i = 1'b0; mdl_on = 1;
        bus_write(2'd2, 8'hA5);
        repeat (40) @(negedge clk);
        bus_write(2'd2, 8'hFF);
        repeat (600) @(negedge clk);
        mdl_on = 0;
        bus_read(2'd1, r); check("R8 collision and done", r, 8'hC0);
        bus_read(2'd2, r); check("R8 rx intact", r, 8'h3C);
        check("R8 tx byte undisturbed", cap, 8'hA5);
        bus_read(2'd1, r); check("R8 flags cleared", r, 8'h00);

        // R1 disabled
        bus_write(2'd0, 8'h90);
        begin
            int e0;
            e0 = edges;
            bus_write(2'd2, 8'hF0);
            repeat (300) @(negedge clk);
            check("R1 no SCLK edges", 8'(edges - e0), 8'd0);
        end
        bus_read(2'd1, r); check("R1 no done", r, 8'h00);
        bus_write(2'd0, 8'h80);
        ss_n_i = 0;
        repeat (4) @(negedge clk);
        check("R1 oe off", {7'd0, miso_oe}, 8'h00);
        ss_n_i = 1;

        if (exp_q.size() != 0) check("scoreboard leftover", 8'(exp_q.size()), 8'd0);
        finish_run();
    end
endmodule